// File: doc/BRIEF.md
# Integer Execute Stage with Overflow Trap

This block is the single-cycle execute stage of a 32-bit load/store integer pipeline. Each cycle it takes an instruction word, the two register operand values read for that instruction and the instruction's program counter. From these it produces a 32-bit result, a register write enable and the next fetch address. Register-register and register-immediate arithmetic and logic instructions are decoded from the opcode field in bits 31:26 and, for register-register forms, the function field in bits 5:0.

Arithmetic comes in two families. The trapping adds and subtracts check for signed overflow. The unsigned variants wrap silently. When a trapping instruction overflows, the stage raises an exception and suppresses the register write. It redirects fetch to a fixed vector, and on the next clock edge it saves the faulting instruction's address in an exception-address register. This register is held in the stage, apart from the register file. A dedicated move instruction copies it into a general-purpose register, so a handler can inspect it.

Top module: `int_exec_unit`

## Requirements
- R1: With opcode 000000, function codes 100000 (ADD), 100001 (ADDU), 100010 (SUB) and 100011 (SUBU) give op_a_i plus or minus op_b_i modulo 2^32, with wr_en_o high when no trap occurs.
- R2: With opcode 000000, function codes 100100, 100101, 100110 and 100111 give the bitwise AND, OR, XOR and NOR of the two operands.
- R3: Function code 101010 sets the result to 1 when op_a_i is less than op_b_i as signed numbers and to 0 otherwise. Function code 101011 makes the same comparison on unsigned numbers.
- R4: The immediate lives in bits 15:0. Opcodes 001000 (ADDI), 001001 (ADDIU), 001010 (SLTI) and 001011 (SLTIU) sign-extend it and apply add, add, signed compare and unsigned compare. Opcodes 001100, 001101 and 001110 zero-extend it and apply AND, OR and XOR. Opcode 001111 gives the immediate in bits 31:16 with bits 15:0 cleared.
- R5: When ADD, ADDI or SUB overflows as a signed operation, exc_o is 1 and wr_en_o is 0.
- R6: ADDU, SUBU, ADDIU, SLTU and SLTIU never raise exc_o, and they write the wrapped result.
- R7: next_pc_o equals the EXC_VECTOR parameter (default 32'h8000_0180) in an exception cycle, and pc_i + 4 otherwise.
- R8: The exception-address register takes pc_i on the clock edge that ends an exception cycle, keeps its value in all other cycles, and clears to 0 on reset.
- R9: Opcode 010000 with bits 25:21 equal to 00000 returns the exception-address register on result_o with wr_en_o high and exc_o low.
- R10: An undefined opcode, or opcode 000000 with an undefined function code, gives wr_en_o 0 and exc_o 0, with next_pc_o equal to pc_i + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word |
| op_a_i | input | 32 | First register operand |
| op_b_i | input | 32 | Second register operand |
| pc_i | input | 32 | Address of the instruction |
| result_o | output | 32 | Value to write to the destination register |
| wr_en_o | output | 1 | Destination register write enable |
| exc_o | output | 1 | Overflow exception raised this cycle |
| next_pc_o | output | 32 | Next fetch address |

## Verification
Some rules can be checked on every cycle, and the assertions cover these. An exception always suppresses the write and selects the vector. The unsigned add never traps. The exception-address register loads the faulting PC after an exception and stays stable without one. The move instruction always reflects that register. The arithmetic itself can only be shown by the bench's scenarios: exact sums, the signed versus unsigned compare split, sign versus zero extension of each immediate form, and overflow at the signed range edges. The scenarios also cover the read-back of a captured address and the silent handling of undefined encodings.

// File: rtl/iexu_pkg.sv
package iexu_pkg;
  localparam int XLEN = 32;
  localparam int IMMW = 16;

  localparam logic [5:0] OPC_RTYPE = 6'b000000;
  localparam logic [5:0] OPC_ADDI  = 6'b001000;
  localparam logic [5:0] OPC_ADDIU = 6'b001001;
  localparam logic [5:0] OPC_SLTI  = 6'b001010;
  localparam logic [5:0] OPC_SLTIU = 6'b001011;
  localparam logic [5:0] OPC_ANDI  = 6'b001100;
  localparam logic [5:0] OPC_ORI   = 6'b001101;
  localparam logic [5:0] OPC_XORI  = 6'b001110;
  localparam logic [5:0] OPC_LUI   = 6'b001111;
  localparam logic [5:0] OPC_SYSC  = 6'b010000;

  localparam logic [5:0] FN_ADD  = 6'b100000;
  localparam logic [5:0] FN_ADDU = 6'b100001;
  localparam logic [5:0] FN_SUB  = 6'b100010;
  localparam logic [5:0] FN_SUBU = 6'b100011;
  localparam logic [5:0] FN_AND  = 6'b100100;
  localparam logic [5:0] FN_OR   = 6'b100101;
  localparam logic [5:0] FN_XOR  = 6'b100110;
  localparam logic [5:0] FN_NOR  = 6'b100111;
  localparam logic [5:0] FN_SLT  = 6'b101010;
  localparam logic [5:0] FN_SLTU = 6'b101011;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLT, ALU_SLTU, ALU_PASSB
  } alu_op_e;

  typedef struct packed {
    logic    valid;
    logic    trap;
    logic    use_imm;
    logic    is_mfc;
    alu_op_e op;
  } ctl_t;
endpackage

// File: rtl/iexu_decode.sv
module iexu_decode
  import iexu_pkg::*;
(
  input  logic [XLEN-1:0] instr_i,
  output ctl_t            ctl_o,
  output logic [XLEN-1:0] imm_o
);
  logic [5:0]      opc, fn;
  logic [IMMW-1:0] imm16;
  logic [XLEN-1:0] imm_sx, imm_zx, imm_hi;
  logic [9:0]      unused_fields;

  assign opc   = instr_i[31:26];
  assign fn    = instr_i[5:0];
  assign imm16 = instr_i[IMMW-1:0];
  assign imm_sx = {{(XLEN-IMMW){imm16[IMMW-1]}}, imm16};
  assign imm_zx = {{(XLEN-IMMW){1'b0}}, imm16};
  assign imm_hi = {imm16, {(XLEN-IMMW){1'b0}}};
  assign unused_fields = instr_i[20:11];

  always_comb begin
    ctl_o = '{valid: 1'b1, trap: 1'b0, use_imm: 1'b0, is_mfc: 1'b0, op: ALU_ADD};
    imm_o = imm_sx;
    unique case (opc)
      OPC_RTYPE: begin
        unique case (fn)
          FN_ADD:  begin ctl_o.op = ALU_ADD; ctl_o.trap = 1'b1; end
          FN_ADDU: ctl_o.op = ALU_ADD;
          FN_SUB:  begin ctl_o.op = ALU_SUB; ctl_o.trap = 1'b1; end
          FN_SUBU: ctl_o.op = ALU_SUB;
          FN_AND:  ctl_o.op = ALU_AND;
          FN_OR:   ctl_o.op = ALU_OR;
          FN_XOR:  ctl_o.op = ALU_XOR;
          FN_NOR:  ctl_o.op = ALU_NOR;
          FN_SLT:  ctl_o.op = ALU_SLT;
          FN_SLTU: ctl_o.op = ALU_SLTU;
          default: ctl_o.valid = 1'b0;
        endcase
      end
      OPC_ADDI:  begin ctl_o.use_imm = 1'b1; ctl_o.trap = 1'b1; end
      OPC_ADDIU: ctl_o.use_imm = 1'b1;
      OPC_SLTI:  begin ctl_o.use_imm = 1'b1; ctl_o.op = ALU_SLT; end
      OPC_SLTIU: begin ctl_o.use_imm = 1'b1; ctl_o.op = ALU_SLTU; end
      OPC_ANDI:  begin ctl_o.use_imm = 1'b1; ctl_o.op = ALU_AND; imm_o = imm_zx; end
      OPC_ORI:   begin ctl_o.use_imm = 1'b1; ctl_o.op = ALU_OR;  imm_o = imm_zx; end
      OPC_XORI:  begin ctl_o.use_imm = 1'b1; ctl_o.op = ALU_XOR; imm_o = imm_zx; end
      OPC_LUI:   begin ctl_o.use_imm = 1'b1; ctl_o.op = ALU_PASSB; imm_o = imm_hi; end
      OPC_SYSC:  begin
        if (instr_i[25:21] == 5'b00000) ctl_o.is_mfc = 1'b1;
        else ctl_o.valid = 1'b0;
      end
      default:   ctl_o.valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/iexu_alu.sv
module iexu_alu
  import iexu_pkg::*;
(
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o,
  output logic            ovf_o
);
  logic [XLEN-1:0] sum, diff;
  logic            add_ovf, sub_ovf;

  assign sum  = a_i + b_i;
  assign diff = a_i - b_i;
  // signed overflow: operand signs vs result sign
  assign add_ovf = (a_i[XLEN-1] == b_i[XLEN-1]) && (sum[XLEN-1]  != a_i[XLEN-1]);
  assign sub_ovf = (a_i[XLEN-1] != b_i[XLEN-1]) && (diff[XLEN-1] != a_i[XLEN-1]);

  always_comb begin
    ovf_o = 1'b0;
    unique case (op_i)
      ALU_ADD:   begin res_o = sum;  ovf_o = add_ovf; end
      ALU_SUB:   begin res_o = diff; ovf_o = sub_ovf; end
      ALU_AND:   res_o = a_i & b_i;
      ALU_OR:    res_o = a_i | b_i;
      ALU_XOR:   res_o = a_i ^ b_i;
      ALU_NOR:   res_o = ~(a_i | b_i);
      ALU_SLT:   res_o = {{(XLEN-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      ALU_SLTU:  res_o = {{(XLEN-1){1'b0}}, (a_i < b_i)};
      ALU_PASSB: res_o = b_i;
      default:   res_o = '0;
    endcase
  end
endmodule

// File: rtl/iexu_epc.sv
module iexu_epc
  import iexu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cap_i,
  input  logic [XLEN-1:0] pc_i,
  output logic [XLEN-1:0] epc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    epc_o <= '0;
    else if (cap_i) epc_o <= pc_i;
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iexu_pkg::*;
#(
  parameter logic [31:0] EXC_VECTOR = 32'h8000_0180
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] instr_i,
  input  logic [31:0] op_a_i,
  input  logic [31:0] op_b_i,
  input  logic [31:0] pc_i,
  output logic [31:0] result_o,
  output logic        wr_en_o,
  output logic        exc_o,
  output logic [31:0] next_pc_o
);
  localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

  ctl_t            ctl;
  logic [XLEN-1:0] imm_ext, alu_b, alu_res, epc_q;
  logic            ovf;

  iexu_decode u_dec (.instr_i(instr_i), .ctl_o(ctl), .imm_o(imm_ext));

  assign alu_b = ctl.use_imm ? imm_ext : op_b_i;

  iexu_alu u_alu (.op_i(ctl.op), .a_i(op_a_i), .b_i(alu_b), .res_o(alu_res), .ovf_o(ovf));

  assign exc_o = ctl.valid && ctl.trap && ovf;

  iexu_epc u_epc (.clk_i(clk_i), .rst_ni(rst_ni), .cap_i(exc_o), .pc_i(pc_i), .epc_o(epc_q));

  assign result_o  = ctl.is_mfc ? epc_q : alu_res;
  assign wr_en_o   = ctl.valid && !exc_o;
  assign next_pc_o = exc_o ? EXC_VECTOR : pc_i + PC_STEP;
endmodule

// File: rtl/iexu_chk.sv
module iexu_chk #(
  parameter logic [31:0] VEC = 32'h8000_0180
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] instr_i,
  input logic [31:0] pc_i,
  input logic [31:0] result_o,
  input logic        wr_en_o,
  input logic        exc_o,
  input logic [31:0] next_pc_o,
  input logic [31:0] epc_q
);
  // R5
  exc_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> !wr_en_o);
  // R7
  exc_vector_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> next_pc_o == VEC);
  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[31:26] == 6'b000000 && instr_i[5:0] == 6'b100001) |-> !exc_o);
  // R8
  epc_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |=> epc_q == $past(pc_i));
  // R8
  epc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_o |=> $stable(epc_q));
  // R9
  mfc_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[31:21] == 11'b010000_00000) |-> (result_o == epc_q && wr_en_o));
endmodule

bind int_exec_unit iexu_chk #(.VEC(EXC_VECTOR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .instr_i(instr_i), .pc_i(pc_i),
  .result_o(result_o), .wr_en_o(wr_en_o), .exc_o(exc_o),
  .next_pc_o(next_pc_o), .epc_q(epc_q)
);

// File: tb/int_exec_unit_test.sv
`timescale 1ns/1ps
module int_exec_unit_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] instr = '0, a = '0, b = '0, pc = '0;
  logic [31:0] res, npc;
  logic        we, exc;
  int checks = 0, errors = 0;

  int_exec_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .op_a_i(a), .op_b_i(b),
    .pc_i(pc), .result_o(res), .wr_en_o(we), .exc_o(exc), .next_pc_o(npc)
  );

  always #2.5 clk = ~clk;

  function automatic logic [31:0] rtype(input logic [5:0] fn);
    return {6'b000000, 5'd1, 5'd2, 5'd3, 5'd0, fn};
  endfunction
  function automatic logic [31:0] itype(input logic [5:0] opc, input logic [15:0] imm);
    return {opc, 5'd1, 5'd2, imm};
  endfunction
  localparam logic [31:0] MFC = {6'b010000, 5'b00000, 5'd26, 5'd14, 11'd0};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [31:0] x, input logic [31:0] y,
                       input logic [31:0] p);
    @(negedge clk);
    instr = i; a = x; b = y; pc = p;
    #1;
  endtask

  task automatic t_reset;
    apply(MFC, 0, 0, 32'h100);
    chk("R8 reset epc", res, 32'h0);
    chk("R9 mfc we", {31'd0, we}, 1);
  endtask

  task automatic t_addsub;
    apply(rtype(6'b100000), 5, 7, 32'h1000);
    chk("R1 add", res, 12); chk("R1 add we", {31'd0, we}, 1);
    chk("R7 next pc", npc, 32'h1004);
    apply(rtype(6'b100001), 32'hFFFF_FFFF, 1, 32'h1004);
    chk("R6 addu wrap", res, 0); chk("R6 addu exc", {31'd0, exc}, 0);
    apply(rtype(6'b100010), 4, 3, 32'h1008);
    chk("R1 sub", res, 1);
    apply(rtype(6'b100011), 3, 4, 32'h100C);
    chk("R6 subu", res, 32'hFFFF_FFFF); chk("R6 subu we", {31'd0, we}, 1);
    apply(rtype(6'b100011), 32'h8000_0000, 1, 32'h1010);
    chk("R6 subu no trap", {31'd0, exc}, 0);
  endtask

  task automatic t_logic;
    apply(rtype(6'b100100), 32'hF0F0_00FF, 32'h0FF0_0F0F, 0); chk("R2 and", res, 32'h00F0_000F);
    apply(rtype(6'b100101), 32'hF0F0_00FF, 32'h0FF0_0F0F, 0); chk("R2 or",  res, 32'hFFF0_0FFF);
    apply(rtype(6'b100110), 32'hF0F0_00FF, 32'h0FF0_0F0F, 0); chk("R2 xor", res, 32'hFF00_0FF0);
    apply(rtype(6'b100111), 32'hF0F0_00FF, 32'h0FF0_0F0F, 0); chk("R2 nor", res, 32'h000F_F000);
  endtask

  task automatic t_compare;
    apply(rtype(6'b101010), 32'hFFFF_FFFF, 1, 0); chk("R3 slt", res, 1);
    apply(rtype(6'b101011), 32'hFFFF_FFFF, 1, 0); chk("R3 sltu", res, 0);
    apply(rtype(6'b101010), 1, 32'hFFFF_FFFF, 0); chk("R3 slt rev", res, 0);
    apply(rtype(6'b101011), 1, 32'hFFFF_FFFF, 0); chk("R3 sltu rev", res, 1);
  endtask

  task automatic t_imm;
    apply(itype(6'b001000, 16'hFFFE), 10, 0, 0); chk("R4 addi", res, 8);
    apply(itype(6'b001001, 16'h8000), 0, 0, 0); chk("R4 addiu sx", res, 32'hFFFF_8000);
    apply(itype(6'b001011, 16'hFFFF), 5, 0, 0); chk("R4 sltiu", res, 1);
    apply(itype(6'b001010, 16'hFFFF), 5, 0, 0); chk("R4 slti", res, 0);
    apply(itype(6'b001100, 16'h8001), 32'hFFFF_FFFF, 0, 0); chk("R4 andi zx", res, 32'h0000_8001);
    apply(itype(6'b001101, 16'h8000), 32'h1234_0000, 0, 0); chk("R4 ori zx", res, 32'h1234_8000);
    apply(itype(6'b001110, 16'hFFFF), 32'hFFFF_0000, 0, 0); chk("R4 xori zx", res, 32'hFFFF_FFFF);
    apply(itype(6'b001111, 16'hABCD), 32'h5555_5555, 0, 0); chk("R4 lui", res, 32'hABCD_0000);
    apply(itype(6'b001001, 16'h0001), 32'h7FFF_FFFF, 0, 0); chk("R6 addiu no trap", {31'd0, exc}, 0);
  endtask

  task automatic t_trap;
    apply(rtype(6'b100000), 32'h7FFF_FFFF, 1, 32'h0040_0100);
    chk("R5 add exc", {31'd0, exc}, 1); chk("R5 add we", {31'd0, we}, 0);
    chk("R7 vector", npc, 32'h8000_0180);
    apply(MFC, 0, 0, 32'h0040_0104);
    chk("R8 epc captured", res, 32'h0040_0100);
    apply(rtype(6'b100001), 1, 1, 32'h0040_0108);
    apply(MFC, 0, 0, 32'h0040_010C);
    chk("R8 epc held", res, 32'h0040_0100);
    apply(rtype(6'b100010), 32'h8000_0000, 1, 32'h0040_0200);
    chk("R5 sub exc", {31'd0, exc}, 1); chk("R5 sub we", {31'd0, we}, 0);
    apply(itype(6'b001000, 16'h0001), 32'h7FFF_FFFF, 0, 32'h0040_0300);
    chk("R5 addi exc", {31'd0, exc}, 1);
    apply(MFC, 0, 0, 32'h0040_0304);
    chk("R9 mfc epc", res, 32'h0040_0300);
    chk("R9 mfc exc", {31'd0, exc}, 0);
  endtask

  task automatic t_undef;
    apply({6'b111111, 26'h0}, 1, 1, 32'h2000);
    chk("R10 bad opc we", {31'd0, we}, 0); chk("R10 bad opc exc", {31'd0, exc}, 0);
    chk("R10 next pc", npc, 32'h2004);
    apply(rtype(6'b000101), 32'h7FFF_FFFF, 1, 32'h2004);
    chk("R10 bad fn we", {31'd0, we}, 0); chk("R10 bad fn exc", {31'd0, exc}, 0);
    apply(MFC, 0, 0, 32'h2008);
    chk("R10 epc untouched", res, 32'h0040_0300);
  endtask

  initial begin
    #10000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_addsub();
    t_logic();
    t_compare();
    t_imm();
    t_trap();
    t_undef();
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule